// File: doc/BRIEF.md
# Burst-Limited Block Copy Engine

This block copies a run of consecutive words from one memory region to another without the processor executing any instructions. Software sets a source address, a destination address and a word count through a small register port. It then writes the control register with its start bit set. The engine asks for the system bus with a request/grant pair. Once granted, it moves each word as a read from the source followed by a write to the destination, stepping both addresses up by one word each time.

To keep the processor from being starved, the engine can hand the bus back after 4, 8 or 16 words. It drops its request for at least one cycle and then asks again, repeating until the whole count has been moved. A fourth setting keeps the bus until the copy is finished. At completion a sticky done flag drives the interrupt line until software clears it.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, all registers read zero, busy and done are 0, and both irq_o and bus_req_o are low.
- R2: Register map by reg_addr_i: 0 is control/status, 1 is the source address, 2 is the destination address, 3 is the word count. Control writes use bit 0 to start, bit 1 to clear done (write 1 to clear) and bits [3:2] to set the burst mode. Status reads return busy in bit 0, done in bit 1 and the mode in bits [3:2]. Reads at offsets 1 to 3 return the live, advancing values.
- R3: A start with a nonzero count raises bus_req_o. The memory port issues cycles only while bus_gnt_i is high.
- R4: Each word is a read at the source address (mem_we_o=0), then a write of that data to the destination address (mem_we_o=1). After completion the source and destination registers hold their start values plus the count, and the count reads 0.
- R5: Burst modes 0, 1 and 2 allow at most 4, 8 and 16 words per grant. After that many words the engine drops bus_req_o for at least one cycle and requests again. Mode 3 keeps the bus until the copy ends, using a single request.
- R6: When the last word is written, done sets, busy clears and irq_o goes high. Done and irq_o stay high until a control write with bit 1 set, or a new start.
- R7: A start with a count of 0 sets done in the next cycle and never raises bus_req_o.
- R8: While busy, writes to offsets 1 to 3 and further starts are ignored.
- R9: While mem_ready_i is low, an issued memory cycle holds its address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Completion interrupt, level |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| mem_req_o | output | 1 | Memory cycle valid |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory cycle completes when high |

## Verification
The hardest case to reach from the ports is the attempt to change the configuration in the middle of a copy. The engine is busy for only a few cycles under a fast grant, so the bench's bus model holds the grant back for fifteen cycles. During that window it rewrites the count, the source address and the start bit. It then checks that the original count is still present and that the original copy lands in memory intact. Burst limits are observed by counting request edges and the most words written under any one grant, while the memory model stalls ready on a fixed cadence.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned MAX_BURST = 16;
  localparam int unsigned BCNT_W    = $clog2(MAX_BURST) + 1;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SRC  = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_LEN  = 2'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR, ST_REL} dma_state_e;
  typedef enum logic [1:0] {BM_4 = 2'd0, BM_8 = 2'd1, BM_16 = 2'd2, BM_FREE = 2'd3} burst_mode_e;

  function automatic logic [BCNT_W-1:0] burst_words(burst_mode_e m);
    case (m)
      BM_4:    return BCNT_W'(4);
      BM_8:    return BCNT_W'(8);
      default: return BCNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              advance_i,
  input  logic              last_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [LEN_W-1:0]  len_o,
  output burst_mode_e       mode_o,
  output logic              start_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  burst_mode_e       mode_q;
  logic              done_q;
  logic              ctrl_wr, cfg_wr, start_req, zero_start, clr_req;

  assign ctrl_wr    = we_i && addr_i == REG_CTRL;
  assign cfg_wr     = we_i && !busy_i;
  assign start_req  = ctrl_wr && wdata_i[0] && !busy_i;
  assign start_o    = start_req && len_q != '0;
  assign zero_start = start_req && len_q == '0;
  assign clr_req    = ctrl_wr && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      mode_q <= BM_4;
      done_q <= 1'b0;
    end else begin
      if (cfg_wr && addr_i == REG_SRC)      src_q <= wdata_i[ADDR_W-1:0];
      else if (advance_i)                   src_q <= src_q + 1'b1;
      if (cfg_wr && addr_i == REG_DST)      dst_q <= wdata_i[ADDR_W-1:0];
      else if (advance_i)                   dst_q <= dst_q + 1'b1;
      if (cfg_wr && addr_i == REG_LEN)      len_q <= wdata_i[LEN_W-1:0];
      else if (advance_i)                   len_q <= len_q - 1'b1;
      if (cfg_wr && ctrl_wr)                mode_q <= burst_mode_e'(wdata_i[3:2]);
      // a completion in the same cycle as a clear wins
      if (last_i || zero_start)             done_q <= 1'b1;
      else if (clr_req || start_o)          done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[0]   = busy_i;
        rdata_o[1]   = done_q;
        rdata_o[3:2] = mode_q;
      end
      REG_SRC: rdata_o[ADDR_W-1:0] = src_q;
      REG_DST: rdata_o[ADDR_W-1:0] = dst_q;
      default: rdata_o[LEN_W-1:0]  = len_q;
    endcase
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign len_o  = len_q;
  assign mode_o = mode_q;
  assign done_o = done_q;

  // R8: count changes only by advancing while a copy runs
  a_r8_len_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !advance_i |=> $stable(len_q));

  // R6: done is sticky until cleared or restarted
  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !clr_req && !start_o |=> done_q);
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  burst_mode_e       mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              gnt_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] data_o,
  output logic              advance_o,
  output logic              last_o,
  output logic              busy_o
);
  dma_state_e        state_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [DATA_W-1:0] data_q;
  logic              step, burst_end;

  assign mem_req_o = (state_q == ST_RD || state_q == ST_WR) && gnt_i;
  assign mem_we_o  = state_q == ST_WR;
  assign step      = mem_req_o && ready_i;
  assign advance_o = mem_we_o && step;
  assign last_o    = advance_o && len_i == LEN_W'(1);
  assign burst_end = mode_i != BM_FREE && (bcnt_q + 1'b1) == burst_words(mode_i);
  assign req_o     = state_q == ST_ARB || state_q == ST_RD || state_q == ST_WR;
  assign busy_o    = state_q != ST_IDLE;
  assign data_o    = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ARB;
          bcnt_q  <= '0;
        end
        ST_ARB: if (gnt_i) state_q <= ST_RD;
        ST_RD: if (step) begin
          data_q  <= rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (step) begin
          if (last_o) state_q <= ST_IDLE;
          else if (burst_end) begin
            state_q <= ST_REL;
            bcnt_q  <= '0;
          end else begin
            state_q <= ST_RD;
            bcnt_q  <= bcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_ARB;  // ST_REL: one cycle with the request down
      endcase
    end
  end

  // R5: bus handed back after a full burst
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_o && burst_end && !last_o |=> !req_o);

  // R5: never more words per grant than the mode allows
  a_r5_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WR |-> (mode_i == BM_FREE || bcnt_q < burst_words(mode_i)));
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic [ADDR_W-1:0] src, dst;
  logic [LEN_W-1:0]  len;
  burst_mode_e       mode;
  logic              start, done, busy, advance, last;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .advance_i(advance), .last_i(last),
    .src_o(src), .dst_o(dst), .len_o(len), .mode_o(mode),
    .start_o(start), .done_o(done)
  );

  dma_engine #(.LEN_W(LEN_W), .DATA_W(DATA_W)) i_engine (
    .clk_i, .rst_ni,
    .start_i(start), .mode_i(mode), .len_i(len),
    .gnt_i(bus_gnt_i), .ready_i(mem_ready_i), .rdata_i(mem_rdata_i),
    .req_o(bus_req_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .data_o(mem_wdata_o), .advance_o(advance), .last_o(last), .busy_o(busy)
  );

  assign mem_addr_o = mem_we_o ? dst : src;
  assign irq_o      = done;

  // R9: stalled cycle keeps its shape
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                 && $stable(mem_wdata_o));

  // R6: last word raises the interrupt and frees the bus
  a_r6_irq_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> irq_o && !bus_req_o);

  // R7: empty copy completes without a request
  a_r7_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == REG_CTRL && reg_wdata_i[0] && !busy && len == '0
    |=> irq_o && !bus_req_o);
endmodule

// File: tb/test_dma_ctrl.sv
module test_dma_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic [7:0] src;
    logic [7:0] dst;
    logic [7:0] len;
    logic [1:0] mode;
    logic [3:0] gdly;
    logic [3:0] stall;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{src: 8'h00, dst: 8'h80, len: 8'd5,  mode: 2'd0, gdly: 4'd0, stall: 4'd0},
    '{src: 8'h10, dst: 8'h88, len: 8'd16, mode: 2'd1, gdly: 4'd2, stall: 4'd3},
    '{src: 8'h20, dst: 8'h98, len: 8'd17, mode: 2'd2, gdly: 4'd1, stall: 4'd0},
    '{src: 8'h30, dst: 8'hB0, len: 8'd20, mode: 2'd3, gdly: 4'd3, stall: 4'd2},
    '{src: 8'h05, dst: 8'hC8, len: 8'd1,  mode: 2'd0, gdly: 4'd0, stall: 4'd0},
    '{src: 8'h40, dst: 8'hD0, len: 8'd8,  mode: 2'd0, gdly: 4'd0, stall: 4'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, mem_req, mem_we, mem_ready;
  logic        bus_gnt;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int          gnt_dly = 0;
  int          stall_div = 0;
  logic        stat_clr = 1'b0;
  int          n_chk = 0, n_err = 0;

  logic [31:0] mem [256];
  int          cyc, gwait, req_rises, wcnt, maxw;
  logic        req_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctrl i_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  function automatic logic [31:0] init_val(logic [7:0] a);
    return {8'hC0, a, a ^ 8'h5A, ~a};
  endfunction

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ready = (stall_div == 0) || (cyc % stall_div != 0);

  // memory, arbiter and bus monitor
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
      cyc <= 0; gwait <= 0; bus_gnt <= 1'b0; req_d <= 1'b0;
      req_rises <= 0; wcnt <= 0; maxw <= 0;
    end else begin
      cyc   <= cyc + 1;
      req_d <= bus_req;
      if (!bus_req) begin
        bus_gnt <= 1'b0; gwait <= 0;
      end else if (!bus_gnt) begin
        if (gwait >= gnt_dly) bus_gnt <= 1'b1;
        else gwait <= gwait + 1;
      end
      if (stat_clr) begin
        req_rises <= 0; maxw <= 0;
      end else if (bus_req && !req_d) req_rises <= req_rises + 1;
      if (!bus_gnt) wcnt <= 0;
      else if (mem_req && mem_we && mem_ready) begin
        wcnt <= wcnt + 1;
        if (!stat_clr && wcnt + 1 > maxw) maxw <= wcnt + 1;
      end
      if (mem_req && mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_stats();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000; i++) begin
      if (irq) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    int bw, exp_b, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 32'h0);
    rd(2'd3, d); chk("R1 len", d, 32'h0);
    rd(2'd1, d); chk("R1 src", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 bus_req", 32'(bus_req), 32'h0);

    // table of copies: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      gnt_dly = int'(VECS[v].gdly);
      stall_div = int'(VECS[v].stall);
      clear_stats();
      wr(2'd1, 32'(VECS[v].src));
      wr(2'd2, 32'(VECS[v].dst));
      wr(2'd3, 32'(VECS[v].len));
      wr(2'd0, {28'h0, VECS[v].mode, 2'b01});
      wait_irq();
      bw = (VECS[v].mode == 2'd0) ? 4 : (VECS[v].mode == 2'd1) ? 8 : 16;
      exp_b = (VECS[v].mode == 2'd3) ? 1 : (int'(VECS[v].len) + bw - 1) / bw;
      bad = 0;
      for (int i = 0; i < int'(VECS[v].len); i++)
        if (mem[8'(VECS[v].dst + 8'(i))] !== init_val(8'(VECS[v].src + 8'(i)))) bad++;
      chk("R4 data copied", 32'(bad), 32'h0);
      chk("R5 request count", 32'(req_rises), 32'(exp_b));
      if (VECS[v].mode == 2'd3) chk("R5 single grant words", 32'(maxw), 32'(VECS[v].len));
      else chk("R5 words per grant within limit", 32'(maxw <= bw), 32'h1);
      chk("R6 irq", 32'(irq), 32'h1);
      rd(2'd0, d); chk("R2 R6 status done", d, {28'h0, VECS[v].mode, 2'b10});
      rd(2'd3, d); chk("R4 len final", d, 32'h0);
      rd(2'd1, d); chk("R4 src final", d, 32'(VECS[v].src) + 32'(VECS[v].len));
      rd(2'd2, d); chk("R4 dst final", d, 32'(VECS[v].dst) + 32'(VECS[v].len));
      wr(2'd0, 32'h2);
      chk("R6 irq cleared", 32'(irq), 32'h0);
    end

    // R7 zero length
    gnt_dly = 0; stall_div = 0;
    clear_stats();
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h1);
    chk("R7 done at once", 32'(irq), 32'h1);
    repeat (5) @(negedge clk);
    chk("R7 no bus request", 32'(req_rises), 32'h0);
    wr(2'd0, 32'h2);

    // R8 writes while busy, grant held back
    gnt_dly = 15;
    clear_stats();
    wr(2'd1, 32'h60);
    wr(2'd2, 32'hE0);
    wr(2'd3, 32'h4);
    wr(2'd0, 32'h1);
    wr(2'd3, 32'h9);
    wr(2'd1, 32'h70);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R8 busy seen", d & 32'h1, 32'h1);
    rd(2'd3, d); chk("R8 len unchanged while busy", d, 32'h4);
    rd(2'd1, d); chk("R8 src unchanged while busy", d, 32'h60);
    wait_irq();
    bad = 0;
    for (int i = 0; i < 4; i++)
      if (mem[8'hE0 + 8'(i)] !== init_val(8'h60 + 8'(i))) bad++;
    chk("R8 original copy intact", 32'(bad), 32'h0);
    chk("R8 no restart", 32'(mem[8'hE4] === init_val(8'hE4)), 32'h1);
    chk("R8 one request", 32'(req_rises), 32'h1);

    summary();
  end
endmodule